// File: doc/BRIEF.md
# Countdown Timer and Pseudo-Random Byte Unit

This peripheral sits beside a small interpreter-style CPU and provides two services. The first is an 8-bit countdown timer. The CPU writes it through a load port, and it counts down by one on every vertical-blank strobe from the video generator, which arrives at 60 Hz. It stops at zero and never wraps. The second is a source of pseudo-random bytes. A 9-bit rotate-and-xor shift register moves one step on each request strobe, and its low eight bits are presented as the random byte.

The state register is nine bits wide on purpose. A maximal-length 8-bit shift register never reaches the all-ones pattern, but the low byte of a 9-bit register can read 0xFF. A step rotates the state right by one position: the old bit 0 moves into bit 8. The result is then XORed with a word whose only possibly-set bit is bit 4, and that bit holds the complement of the old bit 0.

The timer is a two-state machine. `TMR_IDLE` means the count is zero, and `TMR_RUN` means it is nonzero. The transitions are:
- idle→run on a nonzero load;
- run→idle on a zero load;
- run→idle on a vertical-blank strobe that finds the count at one.

Every other event leaves the state where it is. The generator has no mode states: it is a single register that steps when requested.

Top module: `timer_rng_unit`

## Requirements
- R1: After reset the timer output reads 0 and the random byte reads 0x01, which is the low byte of the seed 9'h001.
- R2: When `tmr_load` is high at a rising edge, the timer output equals `tmr_load_val` from the next cycle on.
- R3: A `vblank_pulse` with no load and a nonzero timer lowers the timer by exactly one at that edge.
- R4: A `vblank_pulse` with the timer at 0 leaves it at 0. The timer never wraps to 0xFF.
- R5: When `tmr_load` and `vblank_pulse` are high at the same edge, the loaded value is taken and no decrement is applied to it.
- R6: Each `rnd_req` edge replaces the 9-bit state s with {s[0], s[8:1]} XOR ({8'b0, ~s[0]} << 4), and `rnd_byte` shows bits 7:0 of the new state one cycle after the request.
- R7: With neither load nor vblank, the timer output holds its value. With no `rnd_req`, the random byte holds its value.
- R8: The two functions are independent. `rnd_req` never changes the timer, and `vblank_pulse` or `tmr_load` never steps the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_pulse | input | 1 | One-cycle vertical-blank strobe that decrements the timer |
| tmr_load | input | 1 | Load strobe for the timer |
| tmr_load_val | input | 8 | Value written by `tmr_load` |
| rnd_req | input | 1 | Strobe that steps the random generator once |
| tmr_value | output | 8 | Current timer count |
| rnd_byte | output | 8 | Low eight bits of the generator state |

## Verification
The hardest case to reach is a vertical-blank strobe that lands on the very edge where a load is written. In normal use the video generator and the CPU are not aligned, so this coincidence is rare. The bench forces it: it first drives the timer to a known nonzero count, then raises both strobes in the same cycle. It does this once with a nonzero value and once with zero, and checks that the loaded value survives without a decrement. A long run of back-to-back random requests, several hundred steps, is compared with an independent model of the step rule. This covers the later stretch of the sequence, which short tests never reach.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/rtu_countdown.sv
module rtu_countdown
    import rtu_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_pulse,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (load_en) begin
                    cnt_d   = load_val;
                    state_d = (load_val == ZERO) ? TMR_IDLE : TMR_RUN;
                end
            end
            TMR_RUN: begin
                if (load_en) begin
                    cnt_d   = load_val;
                    state_d = (load_val == ZERO) ? TMR_IDLE : TMR_RUN;
                end else if (dec_pulse) begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) state_d = TMR_IDLE;
                end
            end
            default: begin
                state_d = TMR_IDLE;
                cnt_d   = ZERO;
            end
        endcase
    end

    // outputs
    always_comb begin
        count = cnt_q;
    end
endmodule

// File: rtl/rtu_lfsr.sv
module rtu_lfsr #(
    parameter int             SW   = 9,
    parameter int             OW   = 8,
    parameter int             TAP  = 4,
    parameter logic [SW-1:0]  SEED = 9'h001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [OW-1:0] value
);
    logic [SW-1:0] st_q, st_d, rot, fb;

    always_comb begin
        rot     = {st_q[0], st_q[SW-1:1]};
        fb      = '0;
        fb[TAP] = ~st_q[0];
        st_d    = step ? (rot ^ fb) : st_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    always_comb begin
        value = st_q[OW-1:0];
    end
endmodule

// File: rtl/timer_rng_unit.sv
module timer_rng_unit #(
    parameter int            CW   = 8,
    parameter int            SW   = 9,
    parameter int            TAP  = 4,
    parameter logic [8:0]    SEED = 9'h001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vblank_pulse,
    input  logic       tmr_load,
    input  logic [7:0] tmr_load_val,
    input  logic       rnd_req,
    output logic [7:0] tmr_value,
    output logic [7:0] rnd_byte
);
    localparam int OW = 8;

    logic [CW-1:0] cnt;
    logic [OW-1:0] rv;

    rtu_countdown #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_pulse(vblank_pulse),
        .load_en  (tmr_load),
        .load_val (CW'(tmr_load_val)),
        .count    (cnt)
    );

    rtu_lfsr #(.SW(SW), .OW(OW), .TAP(TAP), .SEED(SW'(SEED))) u_rng (
        .clk  (clk),
        .rst_n(rst_n),
        .step (rnd_req),
        .value(rv)
    );

    assign tmr_value = 8'(cnt);
    assign rnd_byte  = rv;
endmodule

// File: rtl/rtu_checker.sv
module rtu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vblank_pulse,
    input logic       tmr_load,
    input logic [7:0] tmr_load_val,
    input logic       rnd_req,
    input logic [7:0] tmr_value,
    input logic [7:0] rnd_byte
);
    // R2
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |=> tmr_value == $past(tmr_load_val));
    // R3
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_pulse && !tmr_load && tmr_value != 8'd0) |=> tmr_value == $past(tmr_value) - 8'd1);
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_pulse && !tmr_load && tmr_value == 8'd0) |=> tmr_value == 8'd0);
    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vblank_pulse && !tmr_load) |=> $stable(tmr_value));
    // R7
    rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_req |=> $stable(rnd_byte));
endmodule

bind timer_rng_unit rtu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .vblank_pulse(vblank_pulse), .tmr_load(tmr_load),
    .tmr_load_val(tmr_load_val), .rnd_req(rnd_req), .tmr_value(tmr_value),
    .rnd_byte(rnd_byte)
);

// File: tb/sim_timer_rng_unit.sv
`timescale 1ns/1ps
module sim_timer_rng_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vblank_pulse = 1'b0;
    logic       tmr_load = 1'b0;
    logic [7:0] tmr_load_val = 8'd0;
    logic       rnd_req = 1'b0;
    logic [7:0] tmr_value, rnd_byte;

    int checks = 0;
    int errors = 0;
    logic [8:0] model = 9'h001;
    bit done = 1'b0;

    always #4 clk = ~clk;

    timer_rng_unit u0 (
        .clk(clk), .rst_n(rst_n), .vblank_pulse(vblank_pulse), .tmr_load(tmr_load),
        .tmr_load_val(tmr_load_val), .rnd_req(rnd_req), .tmr_value(tmr_value),
        .rnd_byte(rnd_byte)
    );

    function automatic logic [8:0] step9(input logic [8:0] s);
        logic [8:0] f;
        f = 9'd0;
        f[4] = ~s[0];
        return {s[0], s[8:1]} ^ f;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle with given strobes; sample after the edge
    task automatic cyc(input logic vb, input logic ld, input logic [7:0] v, input logic rq);
        vblank_pulse = vb; tmr_load = ld; tmr_load_val = v; rnd_req = rq;
        @(negedge clk);
        if (rq) model = step9(model);
        vblank_pulse = 1'b0; tmr_load = 1'b0; rnd_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = 9'h001;
        chk("R1 timer", tmr_value, 8'h00);
        chk("R1 rnd", rnd_byte, 8'h01);
    endtask

    task automatic t_load_dec();
        cyc(1'b0, 1'b1, 8'd5, 1'b0);
        chk("R2 load", tmr_value, 8'd5);
        for (int i = 4; i >= 2; i--) begin
            cyc(1'b1, 1'b0, 8'd0, 1'b0);
            chk("R3 dec", tmr_value, 8'(i));
        end
        cyc(1'b0, 1'b1, 8'hFF, 1'b0);
        chk("R2 load max", tmr_value, 8'hFF);
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        chk("R3 dec from max", tmr_value, 8'hFE);
    endtask

    task automatic t_floor();
        cyc(1'b0, 1'b1, 8'd1, 1'b0);
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        chk("R3 one to zero", tmr_value, 8'd0);
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        chk("R4 stays zero", tmr_value, 8'd0);
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        chk("R4 stays zero again", tmr_value, 8'd0);
    endtask

    task automatic t_prio();
        cyc(1'b0, 1'b1, 8'd5, 1'b0);
        cyc(1'b1, 1'b1, 8'h40, 1'b0);
        chk("R5 load beats vblank", tmr_value, 8'h40);
        cyc(1'b1, 1'b1, 8'h00, 1'b0);
        chk("R5 zero load beats vblank", tmr_value, 8'h00);
        cyc(1'b1, 1'b1, 8'h01, 1'b0);
        chk("R5 load from idle with vblank", tmr_value, 8'h01);
    endtask

    task automatic t_hold_indep();
        logic [7:0] r0;
        cyc(1'b0, 1'b1, 8'd9, 1'b0);
        r0 = rnd_byte;
        repeat (4) cyc(1'b0, 1'b0, 8'd0, 1'b0);
        chk("R7 timer holds", tmr_value, 8'd9);
        chk("R7 rnd holds", rnd_byte, r0);
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        cyc(1'b0, 1'b1, 8'd3, 1'b0);
        chk("R8 vblank/load leave rnd", rnd_byte, r0);
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        chk("R8 rnd_req leaves timer", tmr_value, 8'd3);
        chk("R6 step after idle", rnd_byte, model[7:0]);
    endtask

    task automatic t_seq();
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        chk("R6 step", rnd_byte, model[7:0]);
        for (int i = 0; i < 600; i++) begin
            cyc(1'b0, 1'b0, 8'd0, 1'b1);
            chk("R6 sequence", rnd_byte, model[7:0]);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_dec();
        t_floor();
        t_prio();
        t_hold_indep();
        t_reset();
        t_seq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule